// File: doc/BRIEF.md
# Pipeline Branch Hazard Controller

This block is the control logic for conditional branches in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). A branch compares two register operands and goes to its target when they are equal. The controller chooses where fetch goes next and sends a redirect address when a branch resolves against the path that was fetched. Instructions on the wrong path are never removed from the pipe. They are marked, and the mark travels with them so that the datapath drops their register-file and data-memory writes. Each one then completes as a NOP.

Three elaboration parameters set the mode. The first chooses where branches resolve: in execute, with a two-cycle taken penalty, or in decode, with a one-cycle penalty. The second chooses the prediction policy: always not-taken, or static direction, where a backward branch is predicted taken in decode. The third enables an architectural delay slot, in which the instruction right after a branch always completes. The controller assumes the pipe advances every cycle. The datapath supplies the operands and addresses that belong to the branch in the resolving stage. Three counters record resolved branches, mispredictions and squashed instruction slots.

Top module: `branch_hazard_ctrl`

## Requirements
- R1: A branch that is live in the resolve stage (valid, decoded as a branch, not squashed) is taken exactly when `cmp_a` equals `cmp_b`, and a taken redirect goes to `res_target`.
- R2: `pc_sel` encodes 0 = sequential, 1 = predicted target from decode (`d_target`), 2 = correction (`redirect_pc`). Under the not-taken policy, a branch that resolves not taken leaves `pc_sel` at 0 and asserts no kill bit.
- R3: With late resolve, a mispredicted branch in execute sets `pc_sel` to 2 in the same cycle and asserts `kill[0]` (fetch) and `kill[1]` (decode).
- R4: `kill[s]` flags the instruction currently in stage s (0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback). A flagged instruction stays flagged one stage further on each cycle, so it reaches memory and writeback with its write disable asserted.
- R5: With early resolve, a taken branch in decode sets `pc_sel` to 2 toward `res_target` and kills only the fetch slot. A not-taken branch causes no redirect.
- R6: Under the static-direction policy with late resolve, a live backward branch in decode sets `pc_sel` to 1 with `redirect_pc` = `d_target` and kills the fetch slot. A forward branch leaves fetch sequential.
- R7: Under the static-direction policy, a backward branch that resolves not taken redirects (`pc_sel` 2) to `res_fallthru` and kills the younger target-path slots. A backward branch that resolves taken causes no further redirect.
- R8: In delay-slot mode, the instruction immediately following a branch is never killed by that branch. With early resolve, a taken branch asserts no kill bit.
- R9: A squashed branch that reaches the resolve stage causes no redirect and is not counted as resolved.
- R10: `cnt_resolved` counts live branches reaching the resolve stage. `cnt_mispredict` counts those whose outcome differs from the prediction. `cnt_squashed` counts valid, not already squashed fetch and decode slots killed in a cycle.
- R11: After reset, `pc_sel` is 0, every kill bit is 0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid | input | 1 | Fetch stage holds an instruction |
| d_valid | input | 1 | Decode stage holds an instruction |
| d_branch | input | 1 | Decode instruction is a conditional branch |
| d_backward | input | 1 | Decode branch jumps backward |
| d_target | input | ADDR_W | Target of the decode branch, used for prediction |
| x_valid | input | 1 | Execute stage holds an instruction |
| x_branch | input | 1 | Execute instruction is a conditional branch |
| cmp_a | input | DATA_W | First compared operand of the resolving branch |
| cmp_b | input | DATA_W | Second compared operand of the resolving branch |
| res_target | input | ADDR_W | Target address of the resolving branch |
| res_fallthru | input | ADDR_W | Sequential address after the resolving branch |
| pc_sel | output | 2 | Next-PC select: 0 sequential, 1 predicted, 2 correction |
| redirect_pc | output | ADDR_W | Address used when `pc_sel` is not 0 |
| kill | output | 5 | Per-stage write-disable flags, index 0 fetch to 4 writeback |
| cnt_resolved | output | CNT_W | Resolved branch count |
| cnt_mispredict | output | CNT_W | Misprediction count |
| cnt_squashed | output | CNT_W | Squashed slot count |

## Verification
The hardest case to reach from the ports is a branch that is itself on the wrong path and arrives at the resolve stage with operands that would make it taken. The stimulus produces it by resolving a taken branch and, in the very next cycle, presenting another branch with equal operands at the execute stage. That instruction is the one the first branch flagged, so the bench expects no redirect and an unchanged resolved count. A second hard case is the static-direction round trip: a backward branch first redirects fetch from decode and then resolves not taken one cycle later. The bench drives the two cycles back to back and checks the redirect to the fall-through address.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
    typedef enum logic [1:0] {
        PC_SEQ  = 2'd0,
        PC_PRED = 2'd1,
        PC_FIX  = 2'd2
    } pc_sel_e;

    localparam int NUM_STAGES = 5;

    typedef struct packed {
        logic sqz_d;
        logic sqz_x;
        logic sqz_m;
        logic sqz_w;
        logic pred_x;
    } bhc_state_t;
endpackage

// File: rtl/bhc_predict.sv
module bhc_predict #(
    parameter bit STATIC_DIR = 1'b0
) (
    input  logic backward,
    output logic pred_taken
);
    // static policy: backward predicted taken, forward not taken
    always_comb pred_taken = STATIC_DIR && backward;
endmodule

// File: rtl/bhc_resolve.sv
module bhc_resolve #(
    parameter int DATA_W = 32
) (
    input  logic              live,
    input  logic              pred,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              taken,
    output logic              mispred
);
    logic equal;
    always_comb begin
        equal   = (opa == opb);
        taken   = live && equal;
        mispred = live && (equal != pred);
    end
endmodule

// File: rtl/bhc_counter.sv
module bhc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + W'(inc);

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/branch_hazard_ctrl.sv
module branch_hazard_ctrl
    import bhc_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int DATA_W        = 32,
    parameter int CNT_W         = 16,
    parameter bit EARLY_RESOLVE = 1'b0,
    parameter bit STATIC_DIR    = 1'b0,
    parameter bit DELAY_SLOT    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_valid,
    input  logic              d_valid,
    input  logic              d_branch,
    input  logic              d_backward,
    input  logic [ADDR_W-1:0] d_target,
    input  logic              x_valid,
    input  logic              x_branch,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic [ADDR_W-1:0] res_target,
    input  logic [ADDR_W-1:0] res_fallthru,
    output logic [1:0]        pc_sel,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic [NUM_STAGES-1:0] kill,
    output logic [CNT_W-1:0]  cnt_resolved,
    output logic [CNT_W-1:0]  cnt_mispredict,
    output logic [CNT_W-1:0]  cnt_squashed
);
    localparam int NUM_CNT = 3;

    bhc_state_t st_d, st_q;

    logic d_live, x_live, res_live, res_pred, d_pred;
    logic res_taken, res_mis;
    logic fix, pred_go, kill_f, kill_d;
    logic [1:0] inc_vec [NUM_CNT];
    logic [CNT_W-1:0] cnt_vec [NUM_CNT];

    bhc_predict #(.STATIC_DIR(STATIC_DIR)) u_pred (
        .backward   (d_backward),
        .pred_taken (d_pred)
    );

    // live branches and choice of resolving stage
    always_comb begin
        d_live   = d_valid && d_branch && !st_q.sqz_d;
        x_live   = x_valid && x_branch && !st_q.sqz_x;
        res_live = EARLY_RESOLVE ? d_live : x_live;
        res_pred = EARLY_RESOLVE ? d_pred : st_q.pred_x;
    end

    bhc_resolve #(.DATA_W(DATA_W)) u_res (
        .live    (res_live),
        .pred    (res_pred),
        .opa     (cmp_a),
        .opb     (cmp_b),
        .taken   (res_taken),
        .mispred (res_mis)
    );

    always_comb begin
        st_d = st_q;
        // early resolve: fetch is always sequential, so any taken branch redirects
        fix     = EARLY_RESOLVE ? res_taken : res_mis;
        pred_go = !EARLY_RESOLVE && !fix && d_live && d_pred;

        if (fix)           kill_f = !(EARLY_RESOLVE && DELAY_SLOT);
        else               kill_f = pred_go && !DELAY_SLOT;
        kill_d = fix && !EARLY_RESOLVE && !DELAY_SLOT;

        if (fix) begin
            pc_sel      = PC_FIX;
            redirect_pc = (cmp_a == cmp_b) ? res_target : res_fallthru;
        end else if (pred_go) begin
            pc_sel      = PC_PRED;
            redirect_pc = d_target;
        end else begin
            pc_sel      = PC_SEQ;
            redirect_pc = res_fallthru;
        end

        // wrong-path marks move down with their instructions
        st_d.sqz_d  = kill_f;
        st_d.sqz_x  = st_q.sqz_d || kill_d;
        st_d.sqz_m  = st_q.sqz_x;
        st_d.sqz_w  = st_q.sqz_m;
        st_d.pred_x = pred_go;

        kill = {st_q.sqz_w, st_q.sqz_m, st_q.sqz_x, st_q.sqz_d || kill_d, kill_f};

        inc_vec[0] = {1'b0, res_live};
        inc_vec[1] = {1'b0, res_mis};
        inc_vec[2] = {1'b0, kill_f && f_valid}
                   + {1'b0, kill_d && d_valid && !st_q.sqz_d};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        bhc_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[i]),
            .cnt   (cnt_vec[i])
        );
    end

    assign cnt_resolved   = cnt_vec[0];
    assign cnt_mispredict = cnt_vec[1];
    assign cnt_squashed   = cnt_vec[2];
endmodule

// File: rtl/bhc_checks.sv
module bhc_checks #(
    parameter int CNT_W = 16,
    parameter bit EARLY = 1'b0,
    parameter bit DS    = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       pc_sel,
    input logic [4:0]       kill,
    input logic [CNT_W-1:0] cnt_resolved,
    input logic [CNT_W-1:0] cnt_mispredict
);
    AST_KILL_REACHES_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (kill[3] == $past(kill[2])));   // R4
    AST_KILL_REACHES_WB: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (kill[4] == $past(kill[3])));   // R4
    AST_FIX_KILLS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!DS && pc_sel == 2'd2) |-> kill[0]);             // R3
    AST_SLOT_KEPT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (DS && EARLY && pc_sel == 2'd2) |-> !kill[0]);    // R8
    AST_SLOT_KEPT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (DS && !EARLY && pc_sel == 2'd2) |-> !kill[1]);   // R8
    AST_NO_BACK_TO_BACK_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (!DS && $past(rst_n) && $past(pc_sel) == 2'd2) |-> (pc_sel != 2'd2)); // R9
    AST_MISP_WITHIN_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_mispredict <= cnt_resolved);                  // R10
endmodule

bind branch_hazard_ctrl bhc_checks #(
    .CNT_W (CNT_W),
    .EARLY (EARLY_RESOLVE),
    .DS    (DELAY_SLOT)
) u_checks (
    .clk            (clk),
    .rst_n          (rst_n),
    .pc_sel         (pc_sel),
    .kill           (kill),
    .cnt_resolved   (cnt_resolved),
    .cnt_mispredict (cnt_mispredict)
);

// File: tb/branch_hazard_ctrl_test.sv
module branch_hazard_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    typedef struct packed {
        logic        xb;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] tgt;
        logic [31:0] ft;
        logic [1:0]  sel;
        logic [31:0] pc;
        logic [1:0]  kl;
    } vec_t;

    // late resolve, not-taken policy: taken => correction, F and D killed
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'd5,        32'd5,        32'h100, 32'h44, 2'd2, 32'h100, 2'b11},
        '{1'b1, 32'd5,        32'd6,        32'h100, 32'h44, 2'd0, 32'h0,   2'b00},
        '{1'b0, 32'd7,        32'd7,        32'h180, 32'h48, 2'd0, 32'h0,   2'b00},
        '{1'b1, 32'd0,        32'd0,        32'h200, 32'h4c, 2'd2, 32'h200, 2'b11},
        '{1'b1, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h240, 32'h50, 2'd0, 32'h0,   2'b00},
        '{1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 32'h3C,  32'h54, 2'd2, 32'h3C,  2'b11}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f_valid, d_valid, d_branch, d_backward, x_valid, x_branch;
    logic [31:0] d_target, cmp_a, cmp_b, res_target, res_fallthru;

    logic [1:0]  sel0, sel1, sel2, sel3;
    logic [31:0] rpc0, rpc1, rpc2, rpc3;
    logic [4:0]  kl0, kl1, kl2, kl3;
    logic [15:0] res0, mis0, sq0, res1, mis1, sq1, res2, mis2, sq2, res3, mis3, sq3;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_hazard_ctrl uut (
        .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .d_valid(d_valid),
        .d_branch(d_branch), .d_backward(d_backward), .d_target(d_target),
        .x_valid(x_valid), .x_branch(x_branch), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .res_target(res_target), .res_fallthru(res_fallthru),
        .pc_sel(sel0), .redirect_pc(rpc0), .kill(kl0),
        .cnt_resolved(res0), .cnt_mispredict(mis0), .cnt_squashed(sq0));

    branch_hazard_ctrl #(.EARLY_RESOLVE(1'b1)) uut_early (
        .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .d_valid(d_valid),
        .d_branch(d_branch), .d_backward(d_backward), .d_target(d_target),
        .x_valid(x_valid), .x_branch(x_branch), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .res_target(res_target), .res_fallthru(res_fallthru),
        .pc_sel(sel1), .redirect_pc(rpc1), .kill(kl1),
        .cnt_resolved(res1), .cnt_mispredict(mis1), .cnt_squashed(sq1));

    branch_hazard_ctrl #(.EARLY_RESOLVE(1'b1), .DELAY_SLOT(1'b1)) uut_slot (
        .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .d_valid(d_valid),
        .d_branch(d_branch), .d_backward(d_backward), .d_target(d_target),
        .x_valid(x_valid), .x_branch(x_branch), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .res_target(res_target), .res_fallthru(res_fallthru),
        .pc_sel(sel2), .redirect_pc(rpc2), .kill(kl2),
        .cnt_resolved(res2), .cnt_mispredict(mis2), .cnt_squashed(sq2));

    branch_hazard_ctrl #(.STATIC_DIR(1'b1)) uut_sdir (
        .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .d_valid(d_valid),
        .d_branch(d_branch), .d_backward(d_backward), .d_target(d_target),
        .x_valid(x_valid), .x_branch(x_branch), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .res_target(res_target), .res_fallthru(res_fallthru),
        .pc_sel(sel3), .redirect_pc(rpc3), .kill(kl3),
        .cnt_resolved(res3), .cnt_mispredict(mis3), .cnt_squashed(sq3));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        d_branch = 1'b0; d_backward = 1'b0; x_valid = 1'b0; x_branch = 1'b0;
        cmp_a = 32'd1; cmp_b = 32'd2; d_target = '0;
        res_target = '0; res_fallthru = '0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        idle();
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r0, m3;
        f_valid = 1'b1; d_valid = 1'b1;
        idle();
        repeat (3) tick();
        #1;
        // R11 reset state
        chk("R11 sel", {sel0, sel1, sel2, sel3}, 8'h00);
        chk("R11 kill", {kl0, kl1, kl2, kl3}, 20'h0);
        chk("R11 counters", {res0, mis0, sq0, res3}, 64'h0);
        tick();
        rst_n = 1'b1;
        idle_cycles(2);

        // R1 R2 R3 table walk on default controller
        for (int v = 0; v < NV; v++) begin
            x_valid = VECS[v].xb; x_branch = VECS[v].xb;
            cmp_a = VECS[v].a; cmp_b = VECS[v].b;
            res_target = VECS[v].tgt; res_fallthru = VECS[v].ft;
            #1;
            chk("R2 pc_sel", sel0, VECS[v].sel);
            chk("R3 kill F/D", kl0[1:0], VECS[v].kl);
            if (VECS[v].sel == 2'd2) chk("R1 redirect", rpc0, VECS[v].pc);
            tick();
            idle_cycles(2);
        end
        #1;
        // R10 counters: 5 resolved, 3 mispredicted, 6 slots
        chk("R10 resolved", res0, 16'd5);
        chk("R10 mispredict", mis0, 16'd3);
        chk("R10 squashed", sq0, 16'd6);
        idle_cycles(3);

        // R4 mark travels to memory and writeback
        x_valid = 1'b1; x_branch = 1'b1; cmp_a = 32'd9; cmp_b = 32'd9; res_target = 32'h500;
        tick(); idle(); #1;
        chk("R4 kill D/X at +1", kl0[2:1], 2'b11);
        tick(); #1;
        chk("R4 kill M at +2", kl0[3], 1'b1);
        tick(); #1;
        chk("R4 kill W at +3", kl0[4], 1'b1);
        tick(); tick(); #1;
        chk("R4 kill clear", kl0, 5'b0);
        idle_cycles(2);

        // R9 squashed branch reaches execute with equal operands
        #1; r0 = res0;
        x_valid = 1'b1; x_branch = 1'b1; cmp_a = 32'd3; cmp_b = 32'd3; res_target = 32'h600;
        tick();
        cmp_a = 32'd4; cmp_b = 32'd4; res_target = 32'h700; #1;
        chk("R9 no redirect", sel0, 2'd0);
        tick(); idle_cycles(4); #1;
        chk("R9 resolved count", res0, r0 + 16'd1);

        // R5 R8 early resolve, with and without delay slot
        d_branch = 1'b1; cmp_a = 32'd8; cmp_b = 32'd8; res_target = 32'h400; #1;
        chk("R5 early sel", sel1, 2'd2);
        chk("R5 early redirect", rpc1, 32'h400);
        chk("R5 early kill", kl1[1:0], 2'b01);
        chk("R8 slot sel", sel2, 2'd2);
        chk("R8 slot kill", kl2[1:0], 2'b00);
        tick(); idle_cycles(4);
        d_branch = 1'b1; cmp_a = 32'd8; cmp_b = 32'd9; #1;
        chk("R5 early not taken", {sel1, kl1}, 7'b0);
        tick(); idle_cycles(4);

        // R6 R7 static-direction policy
        #1; m3 = mis3;
        d_branch = 1'b1; d_backward = 1'b1; d_target = 32'h80; #1;
        chk("R6 backward predicted", sel3, 2'd1);
        chk("R6 predicted addr", rpc3, 32'h80);
        chk("R6 fetch killed", kl3[0], 1'b1);
        tick(); idle();
        x_valid = 1'b1; x_branch = 1'b1; cmp_a = 32'd1; cmp_b = 32'd2; res_fallthru = 32'h24; #1;
        chk("R7 correction sel", sel3, 2'd2);
        chk("R7 fallthrough", rpc3, 32'h24);
        chk("R7 kill F/D", kl3[1:0], 2'b11);
        tick(); idle_cycles(4);
        d_branch = 1'b1; d_backward = 1'b0; #1;
        chk("R6 forward sequential", {sel3, kl3[0]}, 3'b0);
        tick(); idle();
        x_valid = 1'b1; x_branch = 1'b1; cmp_a = 32'd6; cmp_b = 32'd6; res_target = 32'h90; #1;
        chk("R7 forward taken fix", rpc3, 32'h90);
        tick(); idle_cycles(4);
        d_branch = 1'b1; d_backward = 1'b1; d_target = 32'hA0;
        tick(); idle();
        x_valid = 1'b1; x_branch = 1'b1; cmp_a = 32'd7; cmp_b = 32'd7; #1;
        chk("R7 backward taken no fix", sel3, 2'd0);
        tick(); idle_cycles(2); #1;
        chk("R10 static mispredicts", mis3, m3 + 16'd2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule